// File: doc/BRIEF.md
# Fixed-Point Result Output Converter

This block turns a signed fixed-point result, such as a filter accumulator sum with a parameterised number of integer and fraction bits, into an integer pixel sample. Each sample passes through four steps in a fixed order. First the binary point moves by a signed shift amount. Next the fractional bits are removed under one of three rounding policies. Then, when the output is unsigned, negative values are either floored or replaced by their magnitude. Last, the value is clamped to a range. That range is either a pair of guard-band limits or the full span of the output word.

The input and the output are plain valid/data streams. The configuration (shift, rounding mode, negative policy and guard-band limits) is sampled together with each input word and travels down the pipeline beside it. The configuration may therefore change from one sample to the next. The internal words are wide enough that no step can wrap before the final clamp.

Top module: `fxc_out_conv`

## Requirements
- R1: A sample presented with `in_valid` high appears on `out_data` with `out_valid` high exactly 3 clock cycles later. Cycles without `in_valid` produce no `out_valid`. All `cfg_*` inputs apply to the sample they accompany.
- R2: `cfg_shift` is a 6-bit two's-complement count s. The result is the input value times 2^s, where a negative s moves the binary point left with no loss of bits before rounding. Counts above +16 act as +16 and counts below -16 act as -16.
- R3: `cfg_round` code 0 (and the spare code 3) drops the fraction bits, which rounds toward negative infinity.
- R4: `cfg_round` code 1 rounds to the nearest integer, and an exact half rounds toward positive infinity.
- R5: `cfg_round` code 2 rounds to the nearest integer, and an exact half rounds to the even neighbour.
- R6: With an unsigned output and `cfg_neg_abs` = 0, a negative rounded value gives the lower range limit (0, or the guard-band low limit).
- R7: With an unsigned output and `cfg_neg_abs` = 1, a negative rounded value is replaced by its magnitude, computed without wrap, and that magnitude is then clamped.
- R8: With `cfg_guard_en` = 0 the result saturates to the output word's range, which is 0 to 2^OUT_W-1 when unsigned.
- R9: With `cfg_guard_en` = 1 the result saturates to [`cfg_guard_lo`, `cfg_guard_hi`], read in the output's signedness.
- R10: While `rst_n` is low, `out_valid` and `out_data` are 0.
- R11: Extreme inputs never wrap. The largest positive input at shift +16 gives the upper limit. The most negative input at shift +16 gives the lower limit under floor policy and the upper limit under magnitude policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_INT_W+IN_FRAC_W | Signed fixed-point result |
| cfg_shift | input | 6 | Signed binary-point shift |
| cfg_round | input | 2 | Rounding policy code |
| cfg_neg_abs | input | 1 | Negative policy: 0 floor, 1 magnitude |
| cfg_guard_en | input | 1 | Use guard-band limits |
| cfg_guard_lo | input | OUT_W | Guard-band lower limit |
| cfg_guard_hi | input | OUT_W | Guard-band upper limit |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Integer output sample |

## Verification
Assertions check the following on every cycle:
- the three-cycle valid latency;
- that the scaled word keeps the input's sign (no overflow);
- that rounding moves the truncated value by at most one, and never moves it in truncate mode;
- that a tie under round-half-even lands on an even integer;
- that every output lies inside the active limits, and that negative values obey the selected policy.

The exact numeric result of each mode combination can only be shown by the bench's scenarios. The same holds for the values of ties that are reached through a negative shift, and for per-sample changes of configuration. These scenarios compare the output against a rational-arithmetic reference.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  localparam int SHIFT_W   = 6;
  localparam int SHIFT_LIM = 16;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_EVEN = 2'd2,
    RND_SPARE     = 2'd3
  } rnd_mode_e;

  // Saturate a signed shift request to +/-SHIFT_LIM and bias it to 0..2*SHIFT_LIM.
  function automatic logic [SHIFT_W-1:0] shift_amount(input logic signed [SHIFT_W-1:0] s);
    if (s > 6'sd16)       return 6'd32;
    else if (s < -6'sd16) return 6'd0;
    else                  return 6'(s + 6'sd16);
  endfunction
endpackage

// File: rtl/fxc_scale.sv
module fxc_scale
  import fxc_pkg::*;
#(
  parameter int IN_W = 20,
  parameter int WIDE = IN_W + 2*SHIFT_LIM + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IN_W-1:0]        in_data,
  input  logic [SHIFT_W-1:0]     in_shift,
  output logic                   out_valid,
  output logic signed [WIDE-1:0] out_data
);
  logic [SHIFT_W-1:0]     shift_amt;
  logic signed [WIDE-1:0] ext_data;
  logic signed [WIDE-1:0] scaled;

  assign shift_amt = shift_amount(in_shift);
  assign ext_data  = {{(WIDE-IN_W){in_data[IN_W-1]}}, in_data};
  assign scaled    = ext_data <<< shift_amt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= scaled;
    end
  end

  p_shift_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($signed(in_shift) > 6'sd16)) |-> (shift_amt == 6'd32));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[WIDE-1] == $past(in_data[IN_W-1])));
endmodule

// File: rtl/fxc_round.sv
module fxc_round
  import fxc_pkg::*;
#(
  parameter int WIDE   = 53,
  parameter int FRAC_X = 24,
  parameter int INTW   = WIDE - FRAC_X
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [WIDE-1:0] in_data,
  input  rnd_mode_e              in_mode,
  output logic                   out_valid,
  output logic signed [INTW-1:0] out_q
);
  logic signed [INTW-1:0] trunc_q;
  logic                   half_bit;
  logic                   sticky;
  logic                   inc;
  logic signed [INTW-1:0] q_next;

  function automatic logic round_inc(input rnd_mode_e m, input logic half,
                                     input logic rest, input logic lsb);
    case (m)
      RND_HALF_UP:   return half;
      RND_HALF_EVEN: return half & (rest | lsb);
      default:       return 1'b0;
    endcase
  endfunction

  assign trunc_q  = in_data[WIDE-1:FRAC_X];
  assign half_bit = in_data[FRAC_X-1];
  assign sticky   = |in_data[FRAC_X-2:0];
  assign inc      = round_inc(in_mode, half_bit, sticky, trunc_q[0]);
  assign q_next   = trunc_q + $signed({{(INTW-1){1'b0}}, inc});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      out_q     <= q_next;
    end
  end

  p_round_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((q_next == trunc_q) || (q_next == trunc_q + 1)));

  p_trunc_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((in_mode == RND_TRUNC) || (in_mode == RND_SPARE))) |-> (q_next == trunc_q));

  p_tie_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mode == RND_HALF_EVEN) && half_bit && !sticky) |-> !q_next[0]);
endmodule

// File: rtl/fxc_range.sv
module fxc_range #(
  parameter int INTW       = 29,
  parameter int OUT_W      = 10,
  parameter bit OUT_SIGNED = 1'b0,
  parameter int QW         = INTW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [INTW-1:0] in_q,
  input  logic                   in_neg_abs,
  input  logic                   in_guard_en,
  input  logic [OUT_W-1:0]       in_guard_lo,
  input  logic [OUT_W-1:0]       in_guard_hi,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_data
);
  localparam longint FULL_HI_L = OUT_SIGNED ? ((64'sd1 <<< (OUT_W-1)) - 1) : ((64'sd1 <<< OUT_W) - 1);
  localparam longint FULL_LO_L = OUT_SIGNED ? -(64'sd1 <<< (OUT_W-1)) : 64'sd0;

  function automatic logic signed [QW-1:0] widen(input logic [OUT_W-1:0] v);
    if (OUT_SIGNED) return {{(QW-OUT_W){v[OUT_W-1]}}, v};
    else            return {{(QW-OUT_W){1'b0}}, v};
  endfunction

  logic signed [QW-1:0] q_x;
  logic signed [QW-1:0] lo_lim;
  logic signed [QW-1:0] hi_lim;
  logic                 is_neg;
  logic signed [QW-1:0] conv;
  logic                 clamp_hi;
  logic                 clamp_lo;
  logic signed [QW-1:0] res;
  logic signed [QW-1:0] out_x;

  assign q_x    = {in_q[INTW-1], in_q};
  assign lo_lim = in_guard_en ? widen(in_guard_lo) : QW'(FULL_LO_L);
  assign hi_lim = in_guard_en ? widen(in_guard_hi) : QW'(FULL_HI_L);

  generate
    if (OUT_SIGNED) begin : g_signed_out
      assign is_neg = 1'b0;
    end else begin : g_unsigned_out
      assign is_neg = q_x[QW-1];
    end
  endgenerate

  assign conv     = is_neg ? (in_neg_abs ? -q_x : lo_lim) : q_x;
  assign clamp_hi = conv > hi_lim;
  assign clamp_lo = conv < lo_lim;
  assign res      = clamp_hi ? hi_lim : (clamp_lo ? lo_lim : conv);
  assign out_x    = widen(out_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= res[OUT_W-1:0];
    end
  end

  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_x >= $past(lo_lim)) && (out_x <= $past(hi_lim))));

  p_fits_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (res == widen(res[OUT_W-1:0])));

  p_neg_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_neg && !in_neg_abs) |=> (out_x == $past(lo_lim)));

  p_neg_mag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_neg && in_neg_abs && (-q_x >= lo_lim) && (-q_x <= hi_lim))
      |=> (out_x == -$past(q_x)));
endmodule

// File: rtl/fxc_out_conv.sv
module fxc_out_conv
  import fxc_pkg::*;
#(
  parameter int IN_INT_W   = 12,
  parameter int IN_FRAC_W  = 8,
  parameter int OUT_W      = 10,
  parameter bit OUT_SIGNED = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [IN_INT_W+IN_FRAC_W-1:0] in_data,
  input  logic [5:0]                    cfg_shift,
  input  logic [1:0]                    cfg_round,
  input  logic                          cfg_neg_abs,
  input  logic                          cfg_guard_en,
  input  logic [OUT_W-1:0]              cfg_guard_lo,
  input  logic [OUT_W-1:0]              cfg_guard_hi,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_data
);
  localparam int IN_W   = IN_INT_W + IN_FRAC_W;
  localparam int WIDE   = IN_W + 2*SHIFT_LIM + 1;
  localparam int FRAC_X = IN_FRAC_W + SHIFT_LIM;
  localparam int INTW   = WIDE - FRAC_X;

  // Side-band configuration carried beside each sample.
  rnd_mode_e        rnd_s1;
  logic             nabs_s1, nabs_s2;
  logic             gen_s1, gen_s2;
  logic [OUT_W-1:0] glo_s1, glo_s2, ghi_s1, ghi_s2;

  logic                   scl_valid;
  logic signed [WIDE-1:0] scl_data;
  logic                   rnd_valid;
  logic signed [INTW-1:0] rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_s1  <= RND_TRUNC;
      nabs_s1 <= 1'b0;
      nabs_s2 <= 1'b0;
      gen_s1  <= 1'b0;
      gen_s2  <= 1'b0;
      glo_s1  <= '0;
      glo_s2  <= '0;
      ghi_s1  <= '0;
      ghi_s2  <= '0;
    end else begin
      rnd_s1  <= rnd_mode_e'(cfg_round);
      nabs_s1 <= cfg_neg_abs;
      gen_s1  <= cfg_guard_en;
      glo_s1  <= cfg_guard_lo;
      ghi_s1  <= cfg_guard_hi;
      nabs_s2 <= nabs_s1;
      gen_s2  <= gen_s1;
      glo_s2  <= glo_s1;
      ghi_s2  <= ghi_s1;
    end
  end

  fxc_scale #(.IN_W(IN_W), .WIDE(WIDE)) i_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_shift (cfg_shift),
    .out_valid(scl_valid),
    .out_data (scl_data)
  );

  fxc_round #(.WIDE(WIDE), .FRAC_X(FRAC_X), .INTW(INTW)) i_round (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (scl_valid),
    .in_data  (scl_data),
    .in_mode  (rnd_s1),
    .out_valid(rnd_valid),
    .out_q    (rnd_q)
  );

  fxc_range #(.INTW(INTW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED)) i_range (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rnd_valid),
    .in_q       (rnd_q),
    .in_neg_abs (nabs_s2),
    .in_guard_en(gen_s2),
    .in_guard_lo(glo_s2),
    .in_guard_hi(ghi_s2),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  p_no_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (out_data == '0)));
endmodule

// File: tb/test_fxc_out_conv.sv
module test_fxc_out_conv;
  localparam int  CLK_PERIOD = 10;
  localparam int  IN_INT_W   = 12;
  localparam int  IN_FRAC_W  = 8;
  localparam int  IN_W       = IN_INT_W + IN_FRAC_W;
  localparam int  OUT_W      = 10;
  localparam longint OUT_MAX = (64'sd1 <<< OUT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic [5:0]       cfg_shift = '0;
  logic [1:0]       cfg_round = '0;
  logic             cfg_neg_abs = 1'b0;
  logic             cfg_guard_en = 1'b0;
  logic [OUT_W-1:0] cfg_guard_lo = '0;
  logic [OUT_W-1:0] cfg_guard_hi = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  longint exp_q[$];
  string  tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fxc_out_conv #(.IN_INT_W(IN_INT_W), .IN_FRAC_W(IN_FRAC_W), .OUT_W(OUT_W)) i_fxc_out_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_shift(cfg_shift), .cfg_round(cfg_round), .cfg_neg_abs(cfg_neg_abs),
    .cfg_guard_en(cfg_guard_en), .cfg_guard_lo(cfg_guard_lo), .cfg_guard_hi(cfg_guard_hi),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Exact rational reference: value = x * 2^s / 2^IN_FRAC_W.
  function automatic longint ref_out(longint x, int sh, int rm, bit nabs, bit gen,
                                     longint glo, longint ghi);
    int s;
    longint num, den, fl, rem, r, lo, hi;
    s   = (sh > 16) ? 16 : ((sh < -16) ? -16 : sh);
    num = x * (longint'(1) << (s + 16));
    den = longint'(1) << (IN_FRAC_W + 16);
    fl  = num / den;
    if ((num < 0) && (fl * den != num)) fl = fl - 1;
    rem = num - fl * den;
    r   = fl;
    if (rm == 1 && 2 * rem >= den) r = fl + 1;
    if (rm == 2 && (2 * rem > den || (2 * rem == den && fl % 2 != 0))) r = fl + 1;
    lo = gen ? glo : 0;
    hi = gen ? ghi : OUT_MAX;
    if (r < 0) r = nabs ? -r : lo;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(longint x, int sh, int rm, bit nabs, bit gen, int glo, int ghi, string tag);
    @(negedge clk);
    in_valid     = 1'b1;
    in_data      = x[IN_W-1:0];
    cfg_shift    = sh[5:0];
    cfg_round    = rm[1:0];
    cfg_neg_abs  = nabs;
    cfg_guard_en = gen;
    cfg_guard_lo = glo[OUT_W-1:0];
    cfg_guard_hi = ghi[OUT_W-1:0];
    exp_q.push_back(ref_out(x, sh, rm, nabs, gen, glo, ghi));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  // Output comparison, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected valid", 1, 0);
      end else begin
        automatic longint e = exp_q.pop_front();
        automatic string  t = tag_q.pop_front();
        check(longint'(out_data) == e, t, longint'(out_data), e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd20240611));
    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    check(out_data == '0, "R10 out_data in reset", out_data, 0);
    rst_n = 1'b1;
    idle(2);

    // R1: latency of a lone sample
    send(640, 0, 0, 0, 0, 0, 0, "R1 lone sample");
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R1 latency", lat, 3);
    idle(4);

    // Rounding ties (R3 R4 R5), 1.0 == 256
    send(640, 0, 0, 0, 0, 0, 0, "R3 trunc 2.5");
    send(640, 0, 3, 0, 0, 0, 0, "R3 spare code 2.5");
    send(640, 0, 1, 0, 0, 0, 0, "R4 half-up 2.5");
    send(640, 0, 2, 0, 0, 0, 0, "R5 even 2.5");
    send(896, 0, 2, 0, 0, 0, 0, "R5 even 3.5");
    send(704, 0, 2, 0, 0, 0, 0, "R5 even 2.75");
    send(1280, -1, 2, 0, 0, 0, 0, "R5 even tie via shift");
    send(1280, -1, 1, 0, 0, 0, 0, "R4 half-up tie via shift");
    // Negative handling (R6 R7)
    send(-640, 0, 0, 1, 0, 0, 0, "R7 abs of trunc -2.5");
    send(-640, 0, 1, 1, 0, 0, 0, "R4 R7 half-up -2.5");
    send(-640, 0, 2, 1, 0, 0, 0, "R5 R7 even -2.5");
    send(-640, 0, 0, 0, 0, 0, 0, "R6 negative floor");
    send(-640, 0, 0, 0, 1, 16, 200, "R6 R9 negative floor guard");
    // Scaling (R2)
    send(768, 4, 0, 0, 0, 0, 0, "R2 shift +4");
    send(40960, -4, 0, 0, 0, 0, 0, "R2 shift -4");
    send(1, 12, 0, 0, 0, 0, 0, "R2 shift +12");
    send(1, 16, 0, 0, 0, 0, 0, "R2 shift +16");
    send(1, 20, 0, 0, 0, 0, 0, "R2 shift above limit");
    send(262144, -20, 1, 0, 0, 0, 0, "R2 shift below limit");
    send(262144, -10, 0, 0, 0, 0, 0, "R2 shift -10");
    // No wrap (R11)
    send((64'sd1 <<< (IN_W-1)) - 1, 16, 0, 0, 0, 0, 0, "R11 max at +16");
    send(-(64'sd1 <<< (IN_W-1)), 16, 0, 1, 0, 0, 0, "R11 min at +16 magnitude");
    send(-(64'sd1 <<< (IN_W-1)), 16, 0, 0, 0, 0, 0, "R11 min at +16 floor");
    send(-(64'sd1 <<< (IN_W-1)), -16, 0, 1, 0, 0, 0, "R11 R7 min at -16 magnitude");
    // Range (R8 R9)
    send(262144, 0, 0, 0, 0, 0, 0, "R8 above full range");
    send(262016, 0, 1, 0, 0, 0, 0, "R8 1023.5 half-up");
    send(261760, 0, 2, 0, 0, 0, 0, "R8 R5 1022.5 even");
    send(64000, 0, 0, 0, 1, 16, 200, "R9 above guard");
    send(1280, 0, 0, 0, 1, 16, 200, "R9 below guard");
    send(25600, 0, 0, 0, 1, 16, 200, "R9 inside guard");
    idle(6);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: random mix, config changing per sample
    for (int i = 0; i < 1500; i++) begin
      longint x;
      int sh, rm, glo, ghi;
      bit nabs, gen;
      x    = longint'($signed(20'($urandom))) >>> ($urandom % 16);
      sh   = int'($urandom % 41) - 20;
      if ($urandom % 2 == 0) sh = int'($urandom % 9) - 4;
      rm   = int'($urandom % 4);
      nabs = 1'($urandom);
      gen  = 1'($urandom);
      glo  = int'($urandom % 512);
      ghi  = glo + int'($urandom % 512);
      send(x, sh, rm, nabs, gen, glo, ghi, "R1 random mix");
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(6);
    check(exp_q.size() == 0, "R1 all samples delivered", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule